// File: doc/BRIEF.md
# Gear-Shifted PI Loop Filter with Frequency Lock Detector

This block is the digital loop filter of an all-digital phase-locked loop. Each time a reference event arrives, it takes a signed phase-error word and passes it through a gained first-order IIR low-pass stage. The filtered value then feeds an integrator and a small proportional tap, and the sum of the two is scaled down into an oscillator control word. All arithmetic is integer. The real-valued coefficients are held as integers scaled by 2^24, and every right shift rounds toward negative infinity.

The control word is multiplied by a gear-selected output gain before the final shift. The gain is 4 while the loop is acquiring and 1 once lock is found. A lock detector counts reference events in fixed windows of 2^12 events. In each window it also counts feedback events. Lock is flagged when the feedback count lies within about 0.1 percent of the window length. The lock flag holds until reset, so the loop never shifts back to the fast gear.

Top module: `pll_loop_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `ctrl_word` becomes 0, `locked` becomes 0, and the filter, integrator and window counters are cleared.
- R2: On a cycle with `ref_tick` low, `ctrl_word` and `locked` keep their values, and `phase_err` has no effect.
- R3: On each reference event, the IIR state s is updated as s = floor((K1*(2^24-A)*e + A*s_prev) / 2^24), saturated to SW signed bits, where K1 = 1591 and A = 16617463 (alpha scaled by 2^24).
- R4: On each reference event, the integrator is updated as acc = acc_prev + s (using the new s). The result saturates to ACC_W signed bits instead of wrapping.
- R5: The pre-gain sum is u = acc + floor(K2*s / 2^24), with K2 = 60.
- R6: After each reference event, `ctrl_word` = floor(u*G / 2^OUT_SHIFT), saturated to CW signed bits. G is 4 if `locked` was 0 before that event and 1 if it was 1.
- R7: A window closes on every 4096th reference event after reset. If the feedback events counted in that window lie in 4092..4100, `locked` goes high after that closing event. The count includes feedback events on cycles with no reference event and on the closing cycle.
- R8: Once high, `locked` stays high until reset, whatever later windows count.
- R9: A window whose feedback count lies outside 4092..4100 leaves `locked` unchanged. The next window starts its count from zero.
- R10: `ctrl_word` clamps at the largest or smallest CW-bit signed value when the scaled sum leaves that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference event strobe; qualifies `phase_err` |
| fb_tick | input | 1 | Feedback event strobe for the lock counter |
| phase_err | input | EW (20) | Signed phase-error word |
| ctrl_word | output | CW (16) | Signed oscillator control word |
| locked | output | 1 | Sticky lock flag |

## Verification
The checks that run on every cycle cover four behaviours. The control word and lock flag do not move without a reference event. The IIR state holds between events. The integrator sticks at its limits instead of wrapping. Lock never falls back once set.

Some behaviour is left to the bench scenarios, which run a bit-exact model of the requirements. These cover the exact arithmetic of the IIR, integrator and proportional tap under extreme and mixed error sequences. They also cover the gear change on the event after lock, and the window tolerance edges on both sides: 4091 and 4101 feedback events fail, while 4092 and 4100 pass.

// File: rtl/lf_pkg.sv
package lf_pkg;

    // fixed-point fraction used by all scaled coefficients
    localparam int FRAC_BITS = 24;

    // coefficients quantized to nearest integer at 2^FRAC_BITS
    localparam int ALPHA_Q  = 16617463;  // 0.990478 * 2^24
    localparam int K2_Q     = 60;        // 3.6e-6 * 2^24
    localparam int K1_INT   = 1591;      // pre-IIR gain

    // output gear gains expressed as left shifts
    localparam int FAST_GAIN_SH = 2;     // x4 while acquiring
    localparam int SLOW_GAIN_SH = 0;     // x1 after lock

    typedef enum logic {
        GEAR_FAST = 1'b0,
        GEAR_SLOW = 1'b1
    } gear_e;

    typedef struct packed {
        logic hit;
        logic win_end;
    } win_res_t;

    function automatic int gear_shift(gear_e g);
        return (g == GEAR_SLOW) ? SLOW_GAIN_SH : FAST_GAIN_SH;
    endfunction

    // lock tolerance: 2^(wl - tol_sh) events, about 0.1 % for tol_sh = 10
    function automatic int lock_tol(int wl, int tol_sh);
        return (wl >= tol_sh) ? (1 << (wl - tol_sh)) : 0;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lf_iir.sv
module lf_iir
    import lf_pkg::*;
#(
    parameter int EW   = 20,
    parameter int SW   = 40,
    parameter int FRAC = FRAC_BITS,
    parameter int K1   = K1_INT,
    parameter int A_Q  = ALPHA_Q
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic signed [EW-1:0] err_i,
    output logic signed [SW-1:0] y_o
);

    localparam int PW = SW + FRAC + 16;
    localparam logic signed [PW-1:0] A_C    = PW'(A_Q);
    localparam logic signed [PW-1:0] ONE_C  = PW'(1) <<< FRAC;
    localparam logic signed [PW-1:0] B_C    = PW'(K1) * (ONE_C - A_C);
    localparam logic signed [PW-1:0] S_MAX  = PW'({(SW-1){1'b1}});
    localparam logic signed [PW-1:0] S_MIN  = ~S_MAX;

    logic signed [SW-1:0] s_q;
    logic signed [PW-1:0] mac;
    logic signed [PW-1:0] shf;
    logic signed [SW-1:0] s_n;

    always_comb begin
        mac = B_C * PW'(err_i) + A_C * PW'(s_q);
        shf = mac >>> FRAC;
        if (shf > S_MAX)      s_n = SW'(S_MAX);
        else if (shf < S_MIN) s_n = SW'(S_MIN);
        else                  s_n = SW'(shf);
    end

    always_ff @(posedge clk) begin
        if (rst)       s_q <= '0;
        else if (tick) s_q <= s_n;
    end

    assign y_o = s_n;

    // R3: filter state only moves on a reference event
    a_r3_state_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(s_q));

endmodule

// File: rtl/lf_pi.sv
module lf_pi
    import lf_pkg::*;
#(
    parameter int SW   = 40,
    parameter int AW   = 48,
    parameter int UW   = 50,
    parameter int FRAC = FRAC_BITS,
    parameter int K2   = K2_Q
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic signed [SW-1:0] y_i,
    output logic signed [UW-1:0] u_o
);

    localparam int PRW = SW + FRAC;
    localparam logic signed [UW-1:0] ACC_MAX = UW'({(AW-1){1'b1}});
    localparam logic signed [UW-1:0] ACC_MIN = ~ACC_MAX;
    localparam logic signed [AW-1:0] ACC_MAX_A = AW'(ACC_MAX);
    localparam logic signed [AW-1:0] ACC_MIN_A = AW'(ACC_MIN);

    logic signed [AW-1:0]  acc_q;
    logic signed [AW-1:0]  acc_n;
    logic signed [UW-1:0]  sum;
    logic signed [PRW-1:0] prod;
    logic signed [UW-1:0]  prop;

    always_comb begin
        sum = UW'(acc_q) + UW'(y_i);
        if (sum > ACC_MAX)      acc_n = ACC_MAX_A;
        else if (sum < ACC_MIN) acc_n = ACC_MIN_A;
        else                    acc_n = AW'(sum);
        prod = PRW'(K2) * PRW'(y_i);
        prop = UW'(prod >>> FRAC);
        u_o  = UW'(acc_n) + prop;
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (tick) acc_q <= acc_n;
    end

    // R4: the integrator clamps at its limits instead of wrapping
    a_r4_sat_high: assert property (@(posedge clk) disable iff (rst)
        (tick && acc_q == ACC_MAX_A && y_i >= 0) |=> acc_q == ACC_MAX_A);
    a_r4_sat_low: assert property (@(posedge clk) disable iff (rst)
        (tick && acc_q == ACC_MIN_A && y_i <= 0) |=> acc_q == ACC_MIN_A);

endmodule

// File: rtl/lf_lock.sv
module lf_lock
    import lf_pkg::*;
#(
    parameter int WL     = 12,
    parameter int TOL_SH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fb_tick,
    output logic locked_o
);

    localparam int CNTW = WL + 2;
    localparam int TOL  = lock_tol(WL, TOL_SH);
    localparam logic [CNTW:0] LO = (CNTW+1)'((1 << WL) - TOL);
    localparam logic [CNTW:0] HI = (CNTW+1)'((1 << WL) + TOL);

    logic [WL-1:0]   wcnt;
    logic [CNTW-1:0] fbc;
    logic [CNTW:0]   total;
    logic            locked_q;
    win_res_t        res;

    always_comb begin
        total       = {1'b0, fbc} + (CNTW+1)'(fb_tick);
        res.win_end = tick && (&wcnt);
        res.hit     = res.win_end && (total >= LO) && (total <= HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            fbc      <= '0;
            locked_q <= 1'b0;
        end else begin
            if (tick) wcnt <= wcnt + 1'b1;
            if (res.win_end)            fbc <= '0;
            else if (fb_tick && !(&fbc)) fbc <= fbc + 1'b1;
            if (res.hit) locked_q <= 1'b1;
        end
    end

    assign locked_o = locked_q;

    // R8: lock is sticky until reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);
    // R7: the lock flag changes only on a reference event
    a_r7_on_ref: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(locked_q));

endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter
    import lf_pkg::*;
#(
    parameter int EW        = 20,
    parameter int SW        = 40,
    parameter int ACC_W     = 48,
    parameter int CW        = 16,
    parameter int OUT_SHIFT = 24,
    parameter int WIN_LOG2  = 12,
    parameter int TOL_SH    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ref_tick,
    input  logic                 fb_tick,
    input  logic signed [EW-1:0] phase_err,
    output logic signed [CW-1:0] ctrl_word,
    output logic                 locked
);

    localparam int UW = max2(ACC_W, SW) + 2;
    localparam int VW = UW + FAST_GAIN_SH + 1;
    localparam logic signed [VW-1:0] C_MAX = VW'({(CW-1){1'b1}});
    localparam logic signed [VW-1:0] C_MIN = ~C_MAX;

    logic signed [SW-1:0] y_w;
    logic signed [UW-1:0] u_w;
    logic                 lock_w;
    gear_e                gear;
    logic signed [VW-1:0] scaled;
    logic signed [CW-1:0] ctrl_n;
    logic signed [CW-1:0] ctrl_q;

    lf_iir #(.EW(EW), .SW(SW)) u_iir (
        .clk   (clk),
        .rst   (rst),
        .tick  (ref_tick),
        .err_i (phase_err),
        .y_o   (y_w)
    );

    lf_pi #(.SW(SW), .AW(ACC_W), .UW(UW)) u_pi (
        .clk  (clk),
        .rst  (rst),
        .tick (ref_tick),
        .y_i  (y_w),
        .u_o  (u_w)
    );

    lf_lock #(.WL(WIN_LOG2), .TOL_SH(TOL_SH)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .tick     (ref_tick),
        .fb_tick  (fb_tick),
        .locked_o (lock_w)
    );

    // gear follows the lock flag registered before this event
    always_comb begin
        gear   = lock_w ? GEAR_SLOW : GEAR_FAST;
        scaled = (VW'(u_w) <<< gear_shift(gear)) >>> OUT_SHIFT;
        if (scaled > C_MAX)      ctrl_n = CW'(C_MAX);
        else if (scaled < C_MIN) ctrl_n = CW'(C_MIN);
        else                     ctrl_n = CW'(scaled);
    end

    always_ff @(posedge clk) begin
        if (rst)           ctrl_q <= '0;
        else if (ref_tick) ctrl_q <= ctrl_n;
    end

    assign ctrl_word = ctrl_q;
    assign locked    = lock_w;

    // R2: output holds between reference events
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !ref_tick |=> $stable(ctrl_word));
    // R1: reset leaves a cleared output
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_word == '0 && !locked));

endmodule

// File: tb/test_pll_loop_filter.sv
module test_pll_loop_filter;

    localparam int EW = 20, SW = 40, AW = 36, CW = 16, OSH = 14, WL = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b0;
    logic fb_tick = 1'b0;
    logic signed [EW-1:0] phase_err = '0;
    logic signed [CW-1:0] ctrl_word;
    logic locked;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pll_loop_filter #(.EW(EW), .SW(SW), .ACC_W(AW), .CW(CW),
                      .OUT_SHIFT(OSH), .WIN_LOG2(WL), .TOL_SH(10))
    i_pll_loop_filter (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .phase_err(phase_err), .ctrl_word(ctrl_word), .locked(locked)
    );

    // independent model state
    logic signed [127:0] ms, macc, mctrl;
    logic                mlock;
    int                  mwcnt, mfbc;

    localparam logic signed [127:0] BQ = 128'sd1591 * (128'sd16777216 - 128'sd16617463);
    localparam logic signed [127:0] AQ = 128'sd16617463;

    localparam logic signed [EW-1:0] VEC [12] = '{
        20'sd524287, 20'sd0, -20'sd524288, 20'sd1, -20'sd1, 20'sd1000,
        20'sd250000, -20'sd123456, 20'sd77, 20'sd524287, 20'sd524287, -20'sd300000
    };

    function automatic logic signed [127:0] clamp(input logic signed [127:0] v, input int w);
        logic signed [127:0] hi, lo;
        hi = (128'sd1 <<< (w - 1)) - 128'sd1;
        lo = -hi - 128'sd1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    task automatic model_reset();
        ms = 0; macc = 0; mctrl = 0; mlock = 1'b0; mwcnt = 0; mfbc = 0;
    endtask

    task automatic model_step(input logic r, input logic signed [EW-1:0] e, input logic f);
        logic signed [127:0] u;
        int g;
        if (r) begin
            ms    = clamp((BQ * 128'(e) + AQ * ms) >>> 24, SW);
            macc  = clamp(macc + ms, AW);
            u     = macc + ((128'sd60 * ms) >>> 24);
            g     = mlock ? 0 : 2;
            mctrl = clamp((u <<< g) >>> OSH, CW);
        end
        if (r && mwcnt == (1 << WL) - 1) begin
            int tot;
            tot = mfbc + (f ? 1 : 0);
            if (tot >= 4092 && tot <= 4100) mlock = 1'b1;
            mfbc  = 0;
            mwcnt = 0;
        end else begin
            if (f && mfbc < (1 << (WL + 2)) - 1) mfbc++;
            if (r) mwcnt++;
        end
    endtask

    task automatic check_outs(input string tag);
        checks++;
        if (ctrl_word !== CW'(mctrl)) begin
            failures++;
            $display("FAIL %s ctrl_word actual=%0d expected=%0d", tag, ctrl_word, CW'(mctrl));
        end
        checks++;
        if (locked !== mlock) begin
            failures++;
            $display("FAIL %s locked actual=%0b expected=%0b", tag, locked, mlock);
        end
    endtask

    task automatic step(input logic r, input logic signed [EW-1:0] e, input logic f, input string tag);
        @(negedge clk);
        ref_tick = r; phase_err = e; fb_tick = f;
        @(posedge clk);
        model_step(r, e, f);
        #1;
        check_outs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_tick = 1'b0; fb_tick = 1'b0; phase_err = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_outs("R1 reset state");
    endtask

    // one window of 4096 reference events, skipping fb on the first `miss`
    task automatic run_window(input int miss, input int extra_fb, input string tag);
        for (int i = 0; i < (1 << WL); i++) begin
            if (i == 100) begin
                for (int k = 0; k < extra_fb; k++) step(1'b0, 20'sd0, 1'b1, tag);
            end
            step(1'b1, EW'(((i % 7) - 3) * 100), (i >= miss), tag);
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // stimulus table: R3 IIR, R4 integrator, R5 proportional sum, R6 fast gear
        foreach (VEC[i]) step(1'b1, VEC[i], 1'b0, "R3 R4 R5 R6 vector");

        // R2: idle cycles with a changing error word leave outputs untouched
        step(1'b0, 20'sd400000, 1'b0, "R2 idle hold");
        step(1'b0, -20'sd400000, 1'b0, "R2 idle hold");
        step(1'b1, 20'sd5, 1'b0, "R2 error only taken on event");

        // R10 and R4: drive hard to the limits and back
        for (int i = 0; i < 300; i++) step(1'b1, 20'sd524287, 1'b0, "R10 R4 positive drive");
        checks++;
        if (ctrl_word !== 16'sh7fff) begin
            failures++;
            $display("FAIL R10 ctrl_word actual=%0d expected=%0d", ctrl_word, 32767);
        end
        for (int i = 0; i < 600; i++) step(1'b1, -20'sd524288, 1'b0, "R10 R4 negative drive");
        checks++;
        if (ctrl_word !== -16'sd32768) begin
            failures++;
            $display("FAIL R10 ctrl_word actual=%0d expected=%0d", ctrl_word, -32768);
        end

        // R1 then lower tolerance edge: 4091 misses, 4092 locks
        do_reset();
        run_window(5, 0, "R9 count 4091");
        checks++;
        if (locked !== 1'b0) begin
            failures++;
            $display("FAIL R9 locked actual=%0b expected=0", locked);
        end
        run_window(4, 0, "R7 count 4092");
        checks++;
        if (locked !== 1'b1) begin
            failures++;
            $display("FAIL R7 locked actual=%0b expected=1", locked);
        end
        // R6: events after lock use the slow gear
        for (int i = 0; i < 8; i++) step(1'b1, 20'sd200000, 1'b0, "R6 slow gear");
        // R8: a window with no feedback does not clear lock
        run_window(1 << WL, 0, "R8 sticky");
        checks++;
        if (locked !== 1'b1) begin
            failures++;
            $display("FAIL R8 locked actual=%0b expected=1", locked);
        end

        // upper tolerance edge: 4100 locks, 4101 misses
        do_reset();
        run_window(0, 4, "R7 count 4100");
        checks++;
        if (locked !== 1'b1) begin
            failures++;
            $display("FAIL R7 upper locked actual=%0b expected=1", locked);
        end
        do_reset();
        run_window(0, 5, "R9 count 4101");
        checks++;
        if (locked !== 1'b0) begin
            failures++;
            $display("FAIL R9 upper locked actual=%0b expected=0", locked);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule